// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block sits in the feedback path of a fractional-N frequency synthesizer. It counts cycles of the divided oscillator clock and, after each programmed count, emits a single-cycle pulse toward the phase detector. The count is not fixed. A third-order delta-sigma interpolator, built as three cascaded first-order accumulators followed by a noise-cancelling difference network, produces a small signed offset once per output period. The next period lasts the integer setting plus that offset. Over time the average division ratio becomes INT + FRAC/MOD, where the modulus MOD may be any value from 2 to 4095.

New settings arrive on three parallel 12-bit inputs together with a one-cycle load strobe. They are held as pending and take effect only at the next division boundary. When they take effect, the interpolator's accumulators and carry history are cleared, so every new setting begins from a known state.

Top module: `fracn_fbdiv`

## Requirements
- R1: `fb_pulse` is high for exactly one clock. The number of clocks from one pulse to the next equals the count of the division cycle that lies between them.
- R2: While `rst` is high, `fb_pulse` is low. After reset the active setting is INT=23, FRAC=0, MOD=2, so the divider divides by exactly 23.
- R3: A setting presented with `ld` high is captured but not applied during the current division cycle, which finishes with the old count. It is applied at the next division boundary. If several loads occur before that boundary, only the last one is applied.
- R4: Applying a setting clears all accumulator residues and carry history. The first division cycle after the boundary counts exactly INT input clocks.
- R5: At each later boundary the interpolator takes one step. Stage 1 adds FRAC to its residue. Stage 2 adds stage 1's new residue. Stage 3 adds stage 2's new residue. Whenever a stage's sum is MOD or more, that stage subtracts MOD and sets its carry for this step.
- R6: The offset of a step is c1 + (c2 − c2 of the previous step) + (c3 − 2·c3 of the previous step + c3 of the step before that), with cleared history counting as 0. It lies in −3..+4. The division cycle after the k-th step counts INT + offset_k clocks.
- R7: With FRAC = 0, every division cycle counts exactly INT clocks.
- R8: After P steps since a setting was applied, the sum of the P offsets minus floor(P·FRAC/MOD) lies in −1..+2.
- R9: On capture, INT below 23 becomes 23 and MOD below 2 becomes 2. A FRAC that is not below the resulting MOD becomes MOD−1.
- R10: Counts from 20 (INT=23, offset −3) up to 4099 (INT=4095, offset +4) are produced exactly, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock being counted |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | One-cycle strobe that captures the three setting inputs |
| int_val | input | 12 | Integer part of the division ratio |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Fractional modulus |
| fb_pulse | output | 1 | One-clock feedback pulse, issued once per division cycle |

## Verification
The pulse is registered. It rises one clock after the internal count reaches its terminal value, so the distance between pulses equals the programmed count. The bench therefore samples `fb_pulse` on falling edges and measures each period from one pulse to the next, never from the strobe itself. A load issued within a period becomes visible only in the period that starts at the next pulse. For that reason each scenario first discards the interval in which the strobe falls, and then compares each following interval against a reference interpolator that advances once per pulse, stepping alongside the design. Deferred loads are checked by counting the clocks already spent in the period when the strobe is given, so that the interval still running is compared against the old count.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    // Signed offset produced by the interpolator each division cycle
    localparam int OFF_W = 4;
    typedef logic signed [OFF_W-1:0] off_t;

    localparam off_t OFF_LO = off_t'(-3);
    localparam off_t OFF_HI = off_t'(4);

    // Number of cascaded first-order stages
    localparam int STAGES = 3;

endpackage

// File: rtl/fn_acc_stage.sv
module fn_acc_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] addend,
    input  logic [W-1:0] modv,
    output logic [W-1:0] res_nxt,
    output logic         carry_nxt
);

    typedef struct packed {
        logic [W-1:0] acc;
    } st_t;

    st_t        st_q, st_d;
    logic [W:0] sum;
    logic [W:0] wrapped;

    always_comb begin
        st_d      = st_q;
        sum       = {1'b0, st_q.acc} + {1'b0, addend};
        wrapped   = sum - {1'b0, modv};
        carry_nxt = (sum >= {1'b0, modv});
        res_nxt   = carry_nxt ? wrapped[W-1:0] : sum[W-1:0];
        if (clr) begin
            st_d.acc = '0;
        end else if (step) begin
            st_d.acc = res_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    acc_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.acc < modv);

    // R4
    acc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q.acc == '0));

endmodule

// File: rtl/fn_mash.sv
module fn_mash
    import fracn_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] frac,
    input  logic [W-1:0] modv,
    output off_t         off_nxt
);

    typedef struct packed {
        logic c2p;
        logic c3p;
        logic c3pp;
    } hist_t;

    hist_t                      h_q, h_d;
    logic [STAGES-1:0][W-1:0]   add_v;
    logic [STAGES-1:0][W-1:0]   res_v;
    logic [STAGES-1:0]          car_v;
    logic signed [4:0]          tot;

    function automatic logic signed [4:0] ext(input logic b);
        return {4'b0000, b};
    endfunction

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign add_v[g] = frac;
            end else begin : g_tail
                assign add_v[g] = res_v[g-1];
            end
            fn_acc_stage #(.W(W)) u_acc (
                .clk       (clk),
                .rst       (rst),
                .clr       (clr),
                .step      (step),
                .addend    (add_v[g]),
                .modv      (modv),
                .res_nxt   (res_v[g]),
                .carry_nxt (car_v[g])
            );
        end
    endgenerate

    always_comb begin
        h_d = h_q;
        tot = ext(car_v[0])
            + ext(car_v[1]) - ext(h_q.c2p)
            + ext(car_v[2]) - (ext(h_q.c3p) <<< 1) + ext(h_q.c3pp);
        off_nxt = off_t'(tot[OFF_W-1:0]);
        if (clr) begin
            h_d = '0;
        end else if (step) begin
            h_d.c2p  = car_v[1];
            h_d.c3p  = car_v[2];
            h_d.c3pp = h_q.c3p;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    // R6
    off_range_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (off_nxt >= OFF_LO && off_nxt <= OFF_HI));

    // R7
    zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (step && frac == '0) |-> (off_nxt == '0));

endmodule

// File: rtl/fn_cfg.sv
module fn_cfg #(
    parameter int W       = 12,
    parameter int INT_MIN = 23,
    parameter int MOD_MIN = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] int_in,
    input  logic [W-1:0] frac_in,
    input  logic [W-1:0] mod_in,
    input  logic         term,
    output logic         apply,
    output logic [W-1:0] int_act,
    output logic [W-1:0] frac_act,
    output logic [W-1:0] mod_act,
    output logic [W-1:0] int_pend
);

    localparam logic [W-1:0] INT_LO = W'(INT_MIN);
    localparam logic [W-1:0] MOD_LO = W'(MOD_MIN);

    typedef struct packed {
        logic         pend;
        logic [W-1:0] p_int;
        logic [W-1:0] p_frac;
        logic [W-1:0] p_mod;
        logic [W-1:0] a_int;
        logic [W-1:0] a_frac;
        logic [W-1:0] a_mod;
    } st_t;

    st_t          st_q, st_d;
    logic [W-1:0] i_s, f_s, m_s;

    always_comb begin
        m_s = (mod_in < MOD_LO) ? MOD_LO : mod_in;
        f_s = (frac_in >= m_s) ? (m_s - 1'b1) : frac_in;
        i_s = (int_in < INT_LO) ? INT_LO : int_in;

        apply = term && st_q.pend;
        st_d  = st_q;
        if (apply) begin
            st_d.a_int  = st_q.p_int;
            st_d.a_frac = st_q.p_frac;
            st_d.a_mod  = st_q.p_mod;
            st_d.pend   = 1'b0;
        end
        if (ld) begin
            st_d.p_int  = i_s;
            st_d.p_frac = f_s;
            st_d.p_mod  = m_s;
            st_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend   <= 1'b0;
            st_q.p_int  <= INT_LO;
            st_q.p_frac <= '0;
            st_q.p_mod  <= MOD_LO;
            st_q.a_int  <= INT_LO;
            st_q.a_frac <= '0;
            st_q.a_mod  <= MOD_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_act  = st_q.a_int;
    assign frac_act = st_q.a_frac;
    assign mod_act  = st_q.a_mod;
    assign int_pend = st_q.p_int;

    // R9
    int_floor_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.a_int >= INT_LO && st_q.p_int >= INT_LO);

    // R9
    frac_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.a_frac < st_q.a_mod && st_q.p_frac < st_q.p_mod);

    // R3
    load_pending_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> st_q.pend);

    // R3
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(st_q.a_int) && $stable(st_q.a_mod));

endmodule

// File: rtl/fn_count.sv
module fn_count #(
    parameter int CW    = 13,
    parameter int RST_N = 23,
    parameter int N_LO  = 20,
    parameter int N_HI  = 4099
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] n_nxt,
    output logic          term,
    output logic          pulse
);

    localparam logic [CW-1:0] CNT_RST = CW'(RST_N - 1);
    localparam logic [CW-1:0] N_MIN_V = CW'(N_LO);
    localparam logic [CW-1:0] N_MAX_V = CW'(N_HI);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pls;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt == '0);
        if (term) begin
            st_d.cnt = n_nxt - 1'b1;
            st_d.pls = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.pls = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= CNT_RST;
            st_q.pls <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pls;

    // R1
    pulse_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R10
    count_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        term |-> (n_nxt >= N_MIN_V && n_nxt <= N_MAX_V));

    // R1
    cnt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < N_MAX_V);

endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv
    import fracn_pkg::*;
#(
    parameter int W       = 12,
    parameter int INT_MIN = 23,
    parameter int MOD_MIN = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] int_val,
    input  logic [W-1:0] frac_val,
    input  logic [W-1:0] mod_val,
    output logic         fb_pulse
);

    localparam int CW   = W + 1;
    localparam int SW   = W + 2;
    localparam int N_LO = INT_MIN + int'(OFF_LO);
    localparam int N_HI = (1 << W) - 1 + int'(OFF_HI);

    logic              term;
    logic              apply;
    logic              step;
    logic [W-1:0]      int_act, frac_act, mod_act, int_pend;
    off_t              off_nxt;
    logic signed [SW-1:0] n_sum;
    logic [CW-1:0]     n_nxt;

    fn_cfg #(.W(W), .INT_MIN(INT_MIN), .MOD_MIN(MOD_MIN)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .int_in   (int_val),
        .frac_in  (frac_val),
        .mod_in   (mod_val),
        .term     (term),
        .apply    (apply),
        .int_act  (int_act),
        .frac_act (frac_act),
        .mod_act  (mod_act),
        .int_pend (int_pend)
    );

    assign step = term && !apply;

    fn_mash #(.W(W)) u_mash (
        .clk     (clk),
        .rst     (rst),
        .clr     (apply),
        .step    (step),
        .frac    (frac_act),
        .modv    (mod_act),
        .off_nxt (off_nxt)
    );

    always_comb begin
        n_sum = $signed({2'b00, int_act}) + SW'(off_nxt);
        if (apply) begin
            n_nxt = {1'b0, int_pend};
        end else begin
            n_nxt = n_sum[CW-1:0];
        end
    end

    fn_count #(.CW(CW), .RST_N(INT_MIN), .N_LO(N_LO), .N_HI(N_HI)) u_count (
        .clk   (clk),
        .rst   (rst),
        .n_nxt (n_nxt),
        .term  (term),
        .pulse (fb_pulse)
    );

    // R10
    sum_positive_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (n_sum > 0));

    // R4
    apply_exact_int_chk: assert property (@(posedge clk) disable iff (rst)
        apply |-> (n_nxt == {1'b0, int_pend}));

endmodule

// File: tb/fracn_fbdiv_bench.sv
module fracn_fbdiv_bench;

    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld  = 1'b0;
    logic [11:0] int_val  = 12'd0;
    logic [11:0] frac_val = 12'd0;
    logic [11:0] mod_val  = 12'd2;
    logic        fb_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // reference interpolator state (R5)
    int m_f, m_m, m_a1, m_a2, m_a3, m_c2p, m_c3p, m_c3pp;

    always #(CLK_P/2) clk = ~clk;

    fracn_fbdiv u_fracn_fbdiv (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .int_val  (int_val),
        .frac_val (frac_val),
        .mod_val  (mod_val),
        .fb_pulse (fb_pulse)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic m_clear();
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2p = 0; m_c3p = 0; m_c3pp = 0;
    endtask

    task automatic m_step(output int o);
        int c1, c2, c3;
        m_a1 += m_f;  c1 = (m_a1 >= m_m); if (c1 != 0) m_a1 -= m_m;
        m_a2 += m_a1; c2 = (m_a2 >= m_m); if (c2 != 0) m_a2 -= m_m;
        m_a3 += m_a2; c3 = (m_a3 >= m_m); if (c3 != 0) m_a3 -= m_m;
        o = c1 + c2 - m_c2p + c3 - 2 * m_c3p + m_c3pp;
        m_c3pp = m_c3p;
        m_c3p  = c3;
        m_c2p  = c2;
    endtask

    // count falling edges until the next pulse is seen
    task automatic next_gap(input int start, output int g);
        g = start;
        do begin
            @(negedge clk);
            g++;
        end while (fb_pulse !== 1'b1);
    endtask

    task automatic strobe(input int i, input int f, input int m);
        int_val  = 12'(i);
        frac_val = 12'(f);
        mod_val  = 12'(m);
        ld       = 1'b1;
        @(negedge clk);
        ld       = 1'b0;
    endtask

    // called at a falling edge on which the pulse is high
    task automatic run_cfg(input int i, input int f, input int m,
                           input int ei, input int ef, input int em,
                           input int nper, input string tag);
        int g, o, sum, d;
        sum = 0;
        strobe(i, f, m);
        next_gap(1, g);
        m_f = ef; m_m = em; m_clear();
        next_gap(0, g);
        chk(g == ei, "R4", g, ei);
        for (int k = 1; k <= nper; k++) begin
            m_step(o);
            sum += o;
            next_gap(0, g);
            chk(g == ei + o, tag, g, ei + o);
            d = sum - (k * ef) / em;
            chk(d >= -1 && d <= 2, "R8", d, 0);
        end
    endtask

    task automatic t_reset();
        int g;
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(fb_pulse == 1'b0, "R2", int'(fb_pulse), 0);
        end
        rst = 1'b0;
        next_gap(0, g);
        next_gap(0, g);
        chk(g == 23, "R2", g, 23);
        @(negedge clk);
        chk(fb_pulse == 1'b0, "R1", int'(fb_pulse), 0);
        next_gap(1, g);
        chk(g == 23, "R1", g, 23);
    endtask

    task automatic t_integer();
        run_cfg(100, 0, 7, 100, 0, 7, 8, "R7");
    endtask

    task automatic t_fraction();
        run_cfg(40, 3, 7, 40, 3, 7, 21, "R5");
        run_cfg(300, 517, 1000, 300, 517, 1000, 40, "R6");
    endtask

    task automatic t_reload();
        // the same setting again must restart from a cleared interpolator
        run_cfg(40, 3, 7, 40, 3, 7, 5, "R4");
    endtask

    task automatic t_clamp();
        run_cfg(5, 9, 0, 23, 1, 2, 6, "R9");
        run_cfg(64, 900, 13, 64, 12, 13, 13, "R9");
    endtask

    task automatic t_extreme();
        run_cfg(23, 4094, 4095, 23, 4094, 4095, 60, "R10");
        run_cfg(4095, 4, 5, 4095, 4, 5, 8, "R10");
    endtask

    task automatic t_defer();
        int g;
        run_cfg(50, 0, 2, 50, 0, 2, 2, "R7");
        repeat (10) @(negedge clk);
        strobe(60, 0, 2);
        next_gap(11, g);
        chk(g == 50, "R3", g, 50);
        next_gap(0, g);
        chk(g == 60, "R3", g, 60);
        repeat (5) @(negedge clk);
        strobe(70, 0, 2);
        repeat (5) @(negedge clk);
        strobe(80, 0, 2);
        next_gap(12, g);
        chk(g == 60, "R3", g, 60);
        next_gap(0, g);
        chk(g == 80, "R3", g, 80);
    endtask

    initial begin
        t_reset();
        t_integer();
        t_fraction();
        t_reload();
        t_clamp();
        t_defer();
        t_extreme();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule